// File: doc/BRIEF.md
# Three-State PWM Command Decoder

This block turns a PWM command that has three valid regions into a clean drive command for a power-stage gate sequencer. Upstream, two comparators digitize the PWM pin: one flag reports that the pin is above the upper window threshold, the other that it is below the lower threshold. The block resynchronizes both flags and sorts each sample into HIGH, LOW or mid-window. It then produces three registered outputs: a high-side on request, a low-side on request and a shutdown request.

The mid window is treated as a real command, but only once it has lasted. A brief pass through the window, such as the edge of a slow PWM transition, keeps the last rail command. A stay of `HOLDOFF_CYC` consecutive samples turns both switches off and raises the shutdown request. An undriven pin rests in the window, so a floating input ends in shutdown. When the input returns to either rail, the block leaves shutdown and follows that rail at once. The hold-off is counted in clock cycles. With a 100 MHz clock, the default of 16 cycles gives the nominal 160 ns dwell.

Top module: `tsd_decoder`

## Requirements
- R1: On the clock edge on which a synchronous active-high `rst` is sampled high, and after it, the outputs are `shut_req`=1, `hs_on`=0 and `ls_on`=0. They stay that way until the first HIGH or LOW sample arrives.
- R2: A sample with `cmp_above`=1 and `cmp_below`=0 is HIGH. It gives `hs_on`=1, `ls_on`=0 and `shut_req`=0.
- R3: A sample with `cmp_above`=0 and `cmp_below`=1 is LOW. It gives `hs_on`=0, `ls_on`=1 and `shut_req`=0.
- R4: A run of fewer than `HOLDOFF_CYC` consecutive mid-window samples leaves all three outputs unchanged. The previous rail command is kept.
- R5: On the `HOLDOFF_CYC`-th consecutive mid-window sample, the block registers `shut_req`=1 with both drive outputs low. It stays that way while the window persists.
- R6: Whenever `shut_req` is 1, `hs_on` and `ls_on` are both 0. Exactly one of the three outputs is high in every cycle.
- R7: A sample with both flags at 0 is mid-window, and so is a sample with both flags at 1.
- R8: Leaving shutdown follows the new rail: a HIGH sample gives `hs_on`=1, a LOW sample gives `ls_on`=1. `shut_req` falls on the same edge.
- R9: An input change reaches the outputs after the third rising edge: two synchronizer stages, then the output register.
- R10: The dwell count restarts on every entry into the window. Two runs of `HOLDOFF_CYC`-1 mid samples separated by one rail sample do not cause shutdown.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmp_above | input | 1 | Asynchronous flag: PWM above the upper window threshold |
| cmp_below | input | 1 | Asynchronous flag: PWM below the lower window threshold |
| hs_on | output | 1 | Registered high-side on request |
| ls_on | output | 1 | Registered low-side on request |
| shut_req | output | 1 | Registered shutdown request, both switches off |

## Verification
Two events can fall on the same clock edge. The first is the hold-off expiry, which would raise the shutdown request. The second is the input leaving the window, which would register a rail command. The bench provokes this by sweeping mid-window dwell lengths from one cycle up to two beyond the hold-off. Each dwell is tried from both rails, with both mid-window flag encodings, and exits to both rails. The dwell that lasts exactly `HOLDOFF_CYC-1` samples must leave the previous command untouched. The dwell of exactly `HOLDOFF_CYC` samples must show one cycle of shutdown before the exit command lands. The bench judges every cycle against a cycle model built from the requirements, with the two-stage synchronizer delay applied to the stimulus.

// File: rtl/tsd_pkg.sv
package tsd_pkg;

  typedef enum logic [1:0] {
    RGN_MID  = 2'd0,
    RGN_HIGH = 2'd1,
    RGN_LOW  = 2'd2
  } region_e;

endpackage

// File: rtl/tsd_sync.sv
module tsd_sync #(
  parameter int WIDTH   = 2,
  parameter int STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d_async,
  output logic [WIDTH-1:0] q_sync
);

  logic [WIDTH-1:0] pipe [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) pipe[i] <= RST_VAL;
    end else begin
      pipe[0] <= d_async;
      for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
    end
  end

  assign q_sync = pipe[STAGES-1];

endmodule

// File: rtl/tsd_classify.sv
module tsd_classify
  import tsd_pkg::*;
(
  input  logic    above,
  input  logic    below,
  output region_e rgn
);

  always_comb begin
    unique case ({above, below})
      2'b10:   rgn = RGN_HIGH;
      2'b01:   rgn = RGN_LOW;
      default: rgn = RGN_MID;   // floating (00) or contradictory (11)
    endcase
  end

endmodule

// File: rtl/tsd_dwell.sv
module tsd_dwell #(
  parameter int HOLDOFF_CYC = 16,
  localparam int CNT_W = $clog2(HOLDOFF_CYC + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic in_mid,
  output logic expire
);

  localparam logic [CNT_W-1:0] LIMIT   = CNT_W'(HOLDOFF_CYC);
  localparam logic [CNT_W-1:0] TRIGGER = CNT_W'(HOLDOFF_CYC - 1);

  logic [CNT_W-1:0] run_cnt;

  // Count consecutive mid samples, saturating at the limit.
  // Reset starts saturated so a window held through reset stays shut.
  always_ff @(posedge clk) begin
    if (rst) begin
      run_cnt <= LIMIT;
    end else if (!in_mid) begin
      run_cnt <= '0;
    end else if (run_cnt != LIMIT) begin
      run_cnt <= run_cnt + 1'b1;
    end
  end

  // This sample is the HOLDOFF_CYC-th of the run, or a later one.
  assign expire = in_mid && (run_cnt >= TRIGGER);

endmodule

// File: rtl/tsd_decoder.sv
module tsd_decoder #(
  parameter int HOLDOFF_CYC = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic cmp_above,
  input  logic cmp_below,
  output logic hs_on,
  output logic ls_on,
  output logic shut_req
);
  import tsd_pkg::*;

  logic [1:0] flags_sync;
  region_e    rgn;
  logic       dwell_expire;

  tsd_sync #(
    .WIDTH  (2),
    .STAGES (SYNC_STAGES),
    .RST_VAL(2'b00)
  ) u_sync (
    .clk    (clk),
    .rst    (rst),
    .d_async({cmp_above, cmp_below}),
    .q_sync (flags_sync)
  );

  tsd_classify u_classify (
    .above(flags_sync[1]),
    .below(flags_sync[0]),
    .rgn  (rgn)
  );

  tsd_dwell #(
    .HOLDOFF_CYC(HOLDOFF_CYC)
  ) u_dwell (
    .clk   (clk),
    .rst   (rst),
    .in_mid(rgn == RGN_MID),
    .expire(dwell_expire)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      hs_on    <= 1'b0;
      ls_on    <= 1'b0;
      shut_req <= 1'b1;
    end else begin
      unique case (rgn)
        RGN_HIGH: begin
          hs_on    <= 1'b1;
          ls_on    <= 1'b0;
          shut_req <= 1'b0;
        end
        RGN_LOW: begin
          hs_on    <= 1'b0;
          ls_on    <= 1'b1;
          shut_req <= 1'b0;
        end
        default: begin
          if (dwell_expire) begin
            hs_on    <= 1'b0;
            ls_on    <= 1'b0;
            shut_req <= 1'b1;
          end
        end
      endcase
    end
  end

endmodule

// File: rtl/tsd_checker.sv
module tsd_checker
  import tsd_pkg::*;
#(
  parameter int HOLDOFF_CYC = 16
) (
  input logic    clk,
  input logic    rst,
  input region_e rgn,
  input logic    hs_on,
  input logic    ls_on,
  input logic    shut_req
);

  int mid_run;

  always_ff @(posedge clk) begin
    if (rst)                     mid_run <= HOLDOFF_CYC;
    else if (rgn != RGN_MID)     mid_run <= 0;
    else if (mid_run < HOLDOFF_CYC) mid_run <= mid_run + 1;
  end

  p_one_active_r6: assert property (@(posedge clk) disable iff (rst)
    $countones({hs_on, ls_on, shut_req}) == 1);

  p_shut_quiet_r6: assert property (@(posedge clk) disable iff (rst)
    shut_req |-> (!hs_on && !ls_on));

  p_follow_high_r2: assert property (@(posedge clk) disable iff (rst)
    (rgn == RGN_HIGH) |=> (hs_on && !ls_on && !shut_req));

  p_follow_low_r3: assert property (@(posedge clk) disable iff (rst)
    (rgn == RGN_LOW) |=> (ls_on && !hs_on && !shut_req));

  p_short_keep_r4: assert property (@(posedge clk) disable iff (rst)
    (rgn == RGN_MID && mid_run < HOLDOFF_CYC - 1)
      |=> $stable({hs_on, ls_on, shut_req}));

  p_dwell_needed_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(shut_req) |-> ($past(rgn) == RGN_MID && $past(mid_run) >= HOLDOFF_CYC - 1));

  p_exit_follow_r8: assert property (@(posedge clk) disable iff (rst)
    $fell(shut_req) |-> (hs_on ^ ls_on));

endmodule

bind tsd_decoder tsd_checker #(
  .HOLDOFF_CYC(HOLDOFF_CYC)
) u_checker (
  .clk     (clk),
  .rst     (rst),
  .rgn     (rgn),
  .hs_on   (hs_on),
  .ls_on   (ls_on),
  .shut_req(shut_req)
);

// File: tb/tb_tsd_decoder.sv
module tb_tsd_decoder;

  localparam int CLK_PERIOD = 10;
  localparam int H          = 5;
  localparam int G_MID = 0, G_HI = 1, G_LO = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cmp_above = 1'b0;
  logic cmp_below = 1'b0;
  logic hs_on, ls_on, shut_req;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  // Bench model: input delayed by two synchronizer stages (R9),
  // then the run-length rule of R4/R5/R10 and the rail rule of R2/R3/R8.
  int d1, d2, run, cmd;   // cmd: 0 off, 1 high-side, 2 low-side
  string cur_tag;
  string edge_tag;

  always #(CLK_PERIOD/2) clk = ~clk;

  tsd_decoder #(.HOLDOFF_CYC(H), .SYNC_STAGES(2)) dut (
    .clk(clk), .rst(rst), .cmp_above(cmp_above), .cmp_below(cmp_below),
    .hs_on(hs_on), .ls_on(ls_on), .shut_req(shut_req)
  );

  task automatic check_now();
    logic [2:0] exp_v, act_v;
    exp_v = {cmd == 1, cmd == 2, cmd == 0};
    act_v = {hs_on, ls_on, shut_req};
    n_checks++;
    if (act_v !== exp_v) begin
      n_fail++;
      $display("FAIL %s: {hs,ls,shut} actual=%b expected=%b at %0t",
               edge_tag, act_v, exp_v, $time);
    end
    if (shut_req === 1'b1) begin
      n_checks++;
      if (hs_on !== 1'b0 || ls_on !== 1'b0) begin
        n_fail++;
        $display("FAIL R6: drive during shutdown actual hs=%b ls=%b expected 0 0",
                 hs_on, ls_on);
      end
    end
  endtask

  // g: region, both11: encode mid as flags 11 instead of 00 (R7)
  task automatic step(int g, bit both11, string tag);
    @(negedge clk);
    check_now();
    case (g)
      G_HI:    begin cmp_above = 1'b1; cmp_below = 1'b0; end
      G_LO:    begin cmp_above = 1'b0; cmp_below = 1'b1; end
      default: begin cmp_above = both11; cmp_below = both11; end
    endcase
    @(posedge clk);
    edge_tag = cur_tag;
    if (d2 == G_MID) begin
      if (run < H) run++;
      if (run >= H) cmd = 0;
    end else begin
      run = 0;
      cmd = d2;
    end
    d2 = d1;
    d1 = g;
    cur_tag = tag;
  endtask

  task automatic hold(int g, bit both11, int n, string tag);
    for (int i = 0; i < n; i++) step(g, both11, tag);
  endtask

  initial begin
    d1 = G_MID; d2 = G_MID; run = H; cmd = 0;
    cur_tag = "R1"; edge_tag = "R1";
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state observed while reset held
    check_now();
    rst = 1'b0;
    hold(G_MID, 0, 6, "R1");
    hold(G_HI, 0, 5, "R2");
    hold(G_LO, 0, 5, "R3");
    hold(G_HI, 0, 1, "R9");
    hold(G_LO, 0, 4, "R9");

    // Sweep: start rail x dwell length x mid encoding x exit rail
    for (int s = 1; s <= 2; s++)
      for (int d = 1; d <= H + 2; d++)
        for (int b = 0; b <= 1; b++)
          for (int e = 1; e <= 2; e++) begin
            hold(s, 0, 4, s == G_HI ? "R2" : "R3");
            hold(G_MID, b[0], d, b ? "R7" : (d < H ? "R4" : "R5"));
            hold(e, 0, 4, "R8");
          end

    // R10: restart of the dwell count on each entry
    hold(G_HI, 0, 4, "R10");
    hold(G_MID, 0, H - 1, "R10");
    hold(G_HI, 0, 1, "R10");
    hold(G_MID, 1, H - 1, "R10");
    hold(G_LO, 0, 1, "R10");
    hold(G_MID, 0, H - 1, "R10");
    hold(G_MID, 0, 4, "R5");
    hold(G_LO, 0, 4, "R8");

    // R1: reset reapplied from an active command
    @(negedge clk);
    rst = 1'b1;
    cmp_above = 1'b1; cmp_below = 1'b0;
    @(posedge clk);
    @(negedge clk);
    n_checks++;
    if ({hs_on, ls_on, shut_req} !== 3'b001) begin
      n_fail++;
      $display("FAIL R1: after reset actual=%b expected=001", {hs_on, ls_on, shut_req});
    end
    @(negedge clk);
    rst = 1'b0;
    d1 = G_MID; d2 = G_MID; run = H; cmd = 0; cur_tag = "R1";
    cmp_above = 1'b0; cmp_below = 1'b0;
    hold(G_MID, 1, 4, "R1");
    hold(G_HI, 0, 4, "R8");
    @(negedge clk);
    check_now();

    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
    end
  end

endmodule